// File: doc/BRIEF.md
# Temperature conversion scheduler

This block decides when a temperature sensor front end starts a conversion and when the result of that conversion may be used. In continuous mode it starts conversions at a period picked from a table of seven rates, from one every 125 ms up to one every 64 s. In shutdown mode it starts nothing unless a one-shot request arrives, and then it runs exactly one conversion. The conversion length depends on the selected resolution: the 8-bit setting takes the shortest time, and every added bit doubles it. When the conversion time has elapsed the block raises a done strobe and captures the sample presented on its data input. Bits finer than the chosen resolution are cleared.

All timing is counted in ticks of an external timebase strobe. Two parameters give the tick counts of the shortest period and the shortest conversion, so a testbench can shrink every interval while the ratios between them stay the same. A dedicated enable write puts the block back into its power-on schedule of one conversion per second. The converter and the data path around this block belong to other blocks.

Top module: `conv_sched`

## Requirements
- R1: While reset is held, `conv_start`, `conv_done` and `busy` are low and `result` is zero. After reset the rate is code 5 (one conversion per 8×PERIOD_BASE_TICKS ticks) and the resolution is code 3 (12 bits). The first conversion starts without waiting a period.
- R2: With a nonzero rate code in force, consecutive `conv_start` pulses are separated by PERIOD_BASE_TICKS times 512, 256, 128, 32, 8, 2, 1 ticks for codes 1 to 7. These are the 64 s, 32 s, 16 s, 4 s, 1 s, 250 ms and 125 ms rates. This holds whenever the conversion is shorter than the period.
- R3: Resolution codes 0, 1, 2, 3 select 8, 9, 10 and 12 bits. The conversion lasts CONV_BASE_TICKS times 1, 2, 4, 16 ticks. `conv_done` rises that many ticks after the `conv_start` cycle, and the start cycle's tick is the first one counted.
- R4: `busy` rises in the same cycle as `conv_start` and falls in the cycle where the single-cycle `conv_done` pulse appears.
- R5: If a period expires while a conversion runs, the next `conv_start` comes in the cycle right after `conv_done`. It is not dropped, and it is not issued twice.
- R6: Rate code 0 is shutdown, and in shutdown no conversion starts by itself. An `os_req` sampled while idle in shutdown gives `conv_start` in the next cycle.
- R7: `os_req` has no effect while `busy` is high, and it has no effect in continuous mode.
- R8: An `en_wr` with `en_val`=1 sets the rate to code 5 whatever the previous rate was. `conv_start` follows two cycles later if the block is idle, and the next one follows 8×PERIOD_BASE_TICKS ticks after that. An `en_wr` with `en_val`=0 selects shutdown. When `en_wr` and `cfg_wr` arrive in the same cycle, `en_wr` decides the rate.
- R9: At `conv_done`, `result` takes the `raw_in` sample with its 4, 3, 2 or 0 lowest bits cleared, for resolution codes 0, 1, 2, 3. `result` changes at no other time.
- R10: The resolution is latched at `conv_start`. A `cfg_wr` during a conversion does not change that conversion's length.
- R11: While `tick` is low, neither the conversion nor the period count advances.
- R12: A `cfg_wr` with a nonzero rate restarts the schedule. If the block is idle, `conv_start` follows two cycles after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe; every count advances only on it |
| cfg_wr | input | 1 | Load `cfg_rate` and `cfg_res` |
| cfg_rate | input | 3 | Rate code: 0 shutdown, 1..7 from slowest to fastest |
| cfg_res | input | 2 | Resolution code: 0..3 for 8, 9, 10, 12 bits |
| en_wr | input | 1 | Enable write strobe |
| en_val | input | 1 | 1 enables at the default rate, 0 selects shutdown |
| os_req | input | 1 | One-shot conversion request, honoured in shutdown only |
| raw_in | input | DATA_W | Sample from the converter, two's complement with 4 fraction bits |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| conv_done | output | 1 | One-cycle pulse when the result is valid |
| busy | output | 1 | A conversion is in progress |
| result | output | DATA_W | Last sample, rounded down to the active resolution |

## Verification
The most delicate coincidence is a period expiring while a conversion is still running. The bench forces it by selecting the 125 ms rate together with 12-bit resolution, so every conversion outlasts the period. It then checks that each start lands in the cycle after the previous done and that starts stay exactly one conversion plus one cycle apart. The second coincidence is a one-shot request arriving while busy: the bench pulses the request just after a one-shot start and checks that no start follows and that the running conversion ends on schedule.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

    typedef enum logic [2:0] {
        RATE_OFF   = 3'd0,
        RATE_64S   = 3'd1,
        RATE_32S   = 3'd2,
        RATE_16S   = 3'd3,
        RATE_4S    = 3'd4,
        RATE_1S    = 3'd5,
        RATE_250MS = 3'd6,
        RATE_125MS = 3'd7
    } rate_e;

    typedef enum logic [1:0] {
        RES_8B  = 2'd0,
        RES_9B  = 2'd1,
        RES_10B = 2'd2,
        RES_12B = 2'd3
    } res_e;

    typedef struct packed {
        rate_e rate;
        res_e  res;
    } sched_cfg_t;

    localparam rate_e RATE_DEFAULT   = RATE_1S;
    localparam res_e  RES_DEFAULT    = RES_12B;
    localparam int    MAX_PERIOD_MUL = 512;
    localparam int    MAX_CONV_MUL   = 16;

    // period length in units of the 125 ms base
    function automatic int period_mult(rate_e r);
        case (r)
            RATE_64S:   return 512;
            RATE_32S:   return 256;
            RATE_16S:   return 128;
            RATE_4S:    return 32;
            RATE_1S:    return 8;
            RATE_250MS: return 2;
            RATE_125MS: return 1;
            default:    return 0;
        endcase
    endfunction

    // conversion length doubles per added bit; 12 bits = 2^4 of the 8-bit time
    function automatic int conv_mult(res_e r);
        case (r)
            RES_8B:  return 1;
            RES_9B:  return 2;
            RES_10B: return 4;
            default: return 16;
        endcase
    endfunction

    // fraction bits below the active resolution
    function automatic int drop_bits(res_e r);
        case (r)
            RES_8B:  return 4;
            RES_9B:  return 3;
            RES_10B: return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/cs_rate_timer.sv
module cs_rate_timer
    import conv_sched_pkg::*;
#(
    parameter int PERIOD_BASE_TICKS = 500
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  cfg_wr,
    input  rate_e cfg_rate,
    input  logic  en_wr,
    input  logic  en_val,
    input  logic  start_go,
    output rate_e rate_q,
    output logic  pending
);
    localparam int PW = $clog2(MAX_PERIOD_MUL * PERIOD_BASE_TICKS + 1);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] plen;
    logic          expire;

    always_comb begin
        plen   = PW'(period_mult(rate_q) * PERIOD_BASE_TICKS);
        expire = (rate_q != RATE_OFF) && tick && (pcnt == plen - PW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q  <= RATE_DEFAULT;
            pcnt    <= '0;
            pending <= 1'b1;
        end else if (en_wr) begin
            rate_q  <= en_val ? RATE_DEFAULT : RATE_OFF;
            pcnt    <= '0;
            pending <= en_val;
        end else if (cfg_wr) begin
            rate_q  <= cfg_rate;
            pcnt    <= '0;
            pending <= (cfg_rate != RATE_OFF);
        end else begin
            if (start_go)
                pending <= 1'b0;
            if (rate_q != RATE_OFF && tick) begin
                if (expire) begin
                    pcnt    <= '0;
                    pending <= 1'b1;
                end else begin
                    pcnt <= pcnt + PW'(1);
                end
            end
        end
    end

    assert_shutdown_no_request_R6: assert property (@(posedge clk) disable iff (rst)
        (rate_q == RATE_OFF) |-> !pending);

    assert_expiry_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (expire && !en_wr && !cfg_wr) |=> pending);

    assert_enable_default_R8: assert property (@(posedge clk) disable iff (rst)
        (en_wr && en_val) |=> (rate_q == RATE_1S && pending));

    assert_stall_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (!tick && !en_wr && !cfg_wr) |=> $stable(pcnt));

endmodule

// File: rtl/cs_conv_timer.sv
module cs_conv_timer
    import conv_sched_pkg::*;
#(
    parameter int CONV_BASE_TICKS = 35
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cfg_wr,
    input  res_e cfg_res,
    input  logic start_go,
    output logic conv_start,
    output logic busy,
    output logic conv_done,
    output logic finishing,
    output res_e res_lat
);
    localparam int CW = $clog2(MAX_CONV_MUL * CONV_BASE_TICKS + 1);

    res_e          res_q;
    logic [CW-1:0] cnt;

    assign finishing = busy && tick && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q      <= RES_DEFAULT;
            res_lat    <= RES_DEFAULT;
            cnt        <= '0;
            busy       <= 1'b0;
            conv_start <= 1'b0;
            conv_done  <= 1'b0;
        end else begin
            conv_start <= start_go;
            conv_done  <= 1'b0;
            if (cfg_wr)
                res_q <= cfg_res;
            if (start_go) begin
                busy    <= 1'b1;
                res_lat <= res_q;
                cnt     <= CW'(conv_mult(res_q) * CONV_BASE_TICKS);
            end else if (busy && tick) begin
                if (finishing) begin
                    busy      <= 1'b0;
                    conv_done <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    assert_start_from_idle_R4: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (busy && !$past(busy)));

    assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (rst)
        conv_done |-> (!busy && $past(busy)));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !conv_done);

    assert_busy_blocks_start_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> !conv_start);

    assert_res_held_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_start) |-> $stable(res_lat));

    assert_no_tick_no_done_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> !conv_done);

endmodule

// File: rtl/cs_result_cap.sv
module cs_result_cap
    import conv_sched_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  res_e              res_sel,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] keep;

    assign keep = {DATA_W{1'b1}} << drop_bits(res_sel);

    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else if (capture)
            result <= raw & keep;
    end

    assert_result_only_at_done_R9: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(result));

    assert_result_rounded_R9: assert property (@(posedge clk) disable iff (rst)
        capture |=> ((result & ~$past(keep)) == '0));

endmodule

// File: rtl/conv_sched.sv
module conv_sched
    import conv_sched_pkg::*;
#(
    parameter int PERIOD_BASE_TICKS = 500,
    parameter int CONV_BASE_TICKS   = 35,
    parameter int DATA_W            = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_rate,
    input  logic [1:0]        cfg_res,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic              os_req,
    input  logic [DATA_W-1:0] raw_in,
    output logic              conv_start,
    output logic              conv_done,
    output logic              busy,
    output logic [DATA_W-1:0] result
);
    sched_cfg_t wcfg;
    rate_e      rate_q;
    res_e       res_lat;
    logic       pending;
    logic       start_go;
    logic       finishing;
    logic       shutdown;

    assign wcfg     = '{rate: rate_e'(cfg_rate), res: res_e'(cfg_res)};
    assign shutdown = (rate_q == RATE_OFF);
    assign start_go = !busy && (pending || (shutdown && os_req));

    cs_rate_timer #(.PERIOD_BASE_TICKS(PERIOD_BASE_TICKS)) u_rate (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cfg_wr   (cfg_wr),
        .cfg_rate (wcfg.rate),
        .en_wr    (en_wr),
        .en_val   (en_val),
        .start_go (start_go),
        .rate_q   (rate_q),
        .pending  (pending)
    );

    cs_conv_timer #(.CONV_BASE_TICKS(CONV_BASE_TICKS)) u_conv (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cfg_wr     (cfg_wr),
        .cfg_res    (wcfg.res),
        .start_go   (start_go),
        .conv_start (conv_start),
        .busy       (busy),
        .conv_done  (conv_done),
        .finishing  (finishing),
        .res_lat    (res_lat)
    );

    cs_result_cap #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .capture (finishing),
        .res_sel (res_lat),
        .raw     (raw_in),
        .result  (result)
    );

    assert_oneshot_start_R6: assert property (@(posedge clk) disable iff (rst)
        (shutdown && os_req && !busy) |=> conv_start);

    assert_oneshot_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && os_req) |=> !conv_start);

endmodule

// File: tb/tb_conv_sched.sv
`timescale 1ns/1ps
module tb_conv_sched;
    localparam int PB = 20;
    localparam int CB = 2;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_rate = 3'd0;
    logic [1:0]    cfg_res = 2'd0;
    logic          en_wr = 1'b0;
    logic          en_val = 1'b0;
    logic          os_req = 1'b0;
    logic [DW-1:0] raw_in = '0;
    logic          conv_start, conv_done, busy;
    logic [DW-1:0] result;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_err = 0;
    bit  over = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    conv_sched #(.PERIOD_BASE_TICKS(PB), .CONV_BASE_TICKS(CB), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .tick(tick), .cfg_wr(cfg_wr), .cfg_rate(cfg_rate),
        .cfg_res(cfg_res), .en_wr(en_wr), .en_val(en_val), .os_req(os_req),
        .raw_in(raw_in), .conv_start(conv_start), .conv_done(conv_done),
        .busy(busy), .result(result)
    );

    function automatic int exp_period(int code);
        case (code)
            1: return 512 * PB;  2: return 256 * PB;  3: return 128 * PB;
            4: return 32 * PB;   5: return 8 * PB;    6: return 2 * PB;
            7: return PB;        default: return 0;
        endcase
    endfunction

    function automatic int exp_conv(int r);
        return CB * (1 << ((r == 3) ? 4 : r));
    endfunction

    function automatic int exp_result(int r, logic [DW-1:0] raw);
        int d;
        d = (r == 0) ? 4 : (r == 1) ? 3 : (r == 2) ? 2 : 0;
        return int'(raw & ({DW{1'b1}} << d));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_start(input int limit, input string req, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (conv_start) begin at = cyc; break; end
        end
        if (at < 0) check(1'b0, {req, " start timeout"}, -1, limit);
    endtask

    task automatic wait_done(input int limit, input string req, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (conv_done) begin at = cyc; break; end
        end
        if (at < 0) check(1'b0, {req, " done timeout"}, -1, limit);
    endtask

    task automatic count_starts(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (conv_start) cnt++;
        end
    endtask

    task automatic do_cfg(input int rate, input int res, output int c);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_rate = 3'(rate); cfg_res = 2'(res); c = cyc;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_en(input bit v, output int c);
        @(negedge clk);
        en_wr = 1'b1; en_val = v; c = cyc;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic pulse_os(output int c, output bit st);
        @(negedge clk);
        os_req = 1'b1; c = cyc;
        @(negedge clk);
        os_req = 1'b0; st = conv_start;
    endtask

    initial begin
        int s0, s1, s2, s3, d0, d1, d2, c, n;
        bit st;
        logic [DW-1:0] rv;
        void'($urandom(32'h5eed_0c11));

        // R1: reset values
        repeat (4) begin
            @(negedge clk);
            check(!conv_start && !conv_done && !busy, "R1 strobes low in reset", {conv_start, conv_done, busy}, 0);
            check(result == '0, "R1 result zero in reset", int'(result), 0);
        end
        @(negedge clk); rst = 1'b0;

        // R1/R2/R3: default schedule and 12-bit length
        wait_start(10, "R1", s0);
        wait_done(200, "R1", d0);
        check(d0 - s0 == exp_conv(3), "R1 R3 default conversion length", d0 - s0, exp_conv(3));
        wait_start(400, "R1", s1);
        check(s1 - s0 == exp_period(5), "R1 R2 default period", s1 - s0, exp_period(5));
        wait_done(200, "R1", d0);

        // R3/R9/R12: every resolution at the 1 s rate
        for (int r = 0; r < 4; r++) begin
            rv = DW'($urandom);
            raw_in = rv;
            do_cfg(5, r, c);
            wait_start(10, "R12", s0);
            check(s0 - c == 2, "R12 restart latency", s0 - c, 2);
            wait_done(200, "R3", d0);
            check(d0 - s0 == exp_conv(r), "R3 conversion length", d0 - s0, exp_conv(r));
            check(int'(result) == exp_result(r, rv), "R9 rounded result", int'(result), exp_result(r, rv));
        end

        // R2: each rate code, fastest first
        for (int code = 7; code >= 1; code--) begin
            do_cfg(code, 0, c);
            wait_start(10, "R12", s0);
            check(s0 - c == 2, "R12 restart latency", s0 - c, 2);
            wait_done(20, "R2", d0);
            wait_start(exp_period(code) + 10, "R2", s1);
            check(s1 - s0 == exp_period(code), "R2 period for rate code", s1 - s0, exp_period(code));
            wait_done(20, "R2", d0);
        end

        // R5: period shorter than the conversion
        do_cfg(7, 3, c);
        wait_start(10, "R5", s1);
        wait_done(200, "R5", d1);
        check(d1 - s1 == exp_conv(3), "R5 long conversion length", d1 - s1, exp_conv(3));
        wait_start(10, "R5", s2);
        check(s2 - d1 == 1, "R5 deferred start after done", s2 - d1, 1);
        wait_done(200, "R5", d2);
        wait_start(10, "R5", s3);
        check(s3 - s2 == exp_conv(3) + 1, "R5 deferred spacing", s3 - s2, exp_conv(3) + 1);

        // R8: enable write restores 1 s rate
        do_en(1'b0, c);
        wait_done(200, "R8", d0);
        do_cfg(7, 0, c);
        wait_start(10, "R8", s0);
        wait_done(20, "R8", d0);
        do_en(1'b1, c);
        wait_start(10, "R8", s0);
        check(s0 - c == 2, "R8 enable restart latency", s0 - c, 2);
        wait_start(exp_period(5) + 10, "R8", s1);
        check(s1 - s0 == exp_period(5), "R8 enable forces default period", s1 - s0, exp_period(5));
        wait_done(20, "R8", d0);

        // R8/R6: en_wr beats cfg_wr; shutdown starts nothing
        @(negedge clk);
        en_wr = 1'b1; en_val = 1'b0; cfg_wr = 1'b1; cfg_rate = 3'd7; cfg_res = 2'd1;
        @(negedge clk);
        en_wr = 1'b0; cfg_wr = 1'b0;
        count_starts(300, n);
        check(n == 0, "R8 R6 no start in shutdown", n, 0);

        // R6/R7: one-shot, then a request while busy
        pulse_os(c, st);
        check(st == 1'b1, "R6 one-shot start next cycle", int'(st), 1);
        s0 = c + 1;
        pulse_os(c, st);
        check(st == 1'b0, "R7 request while busy ignored", int'(st), 0);
        wait_done(50, "R7", d0);
        check(d0 - s0 == exp_conv(1), "R7 conversion unaffected", d0 - s0, exp_conv(1));
        count_starts(20, n);
        check(n == 0, "R7 no late start", n, 0);

        // R10: resolution change during a conversion
        do_cfg(0, 3, c);
        pulse_os(c, st);
        s0 = c + 1;
        do_cfg(0, 0, c);
        wait_done(200, "R10", d0);
        check(d0 - s0 == exp_conv(3), "R10 latched resolution", d0 - s0, exp_conv(3));
        pulse_os(c, st);
        s0 = c + 1;
        wait_done(50, "R10", d0);
        check(d0 - s0 == exp_conv(0), "R10 new resolution next time", d0 - s0, exp_conv(0));

        // R11: timebase stall
        do_cfg(0, 1, c);
        pulse_os(c, st);
        tick = 1'b0;
        n = 0;
        repeat (40) begin
            @(negedge clk);
            if (!busy || conv_done) n++;
        end
        check(n == 0, "R11 frozen while tick low", n, 0);
        tick = 1'b1; c = cyc;
        wait_done(50, "R11", d0);
        check(d0 - c == exp_conv(1), "R11 resumes after stall", d0 - c, exp_conv(1));

        // R7: one-shot ignored in continuous mode
        do_cfg(5, 0, c);
        wait_start(10, "R7", s0);
        wait_done(20, "R7", d0);
        pulse_os(c, st);
        count_starts(50, n);
        check(st == 1'b0 && n == 0, "R7 one-shot ignored when continuous", n + int'(st), 0);

        // Random one-shot conversions in shutdown (R3, R6, R9)
        for (int k = 0; k < 24; k++) begin
            int r;
            r = int'($urandom_range(0, 3));
            rv = DW'($urandom);
            raw_in = rv;
            do_cfg(0, r, c);
            repeat ($urandom_range(0, 5)) @(negedge clk);
            pulse_os(c, st);
            check(st == 1'b1, "R6 random one-shot", int'(st), 1);
            wait_done(200, "R3", d0);
            check(d0 - (c + 1) == exp_conv(r), "R3 random length", d0 - c - 1, exp_conv(r));
            check(int'(result) == exp_result(r, rv), "R9 random result", int'(result), exp_result(r, rv));
        end

        over = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!over) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule